// File: doc/BRIEF.md
# Host-to-Array Buffered Bridge

This block turns a host processor into one more node of a processor array. The host sees a small slave port: a word address, write data, a write strobe and registered read data. Behind that port sit a status word, a control word, a receive-information word, an interrupt-clear word and two buffer windows of 1024 32-bit words each. One window holds outbound data and the other holds inbound data. On the array side the bridge drives the same request/transfer handshake that the array nodes use toward the crossbar, and it answers inbound requests with the same response codes.

To send, the host reads the status word until busy is clear. It then fills the transmit window and writes the control word with the start bit set. The bridge raises its request toward the chosen node and waits for a grant. It then streams the words out one at a time, advancing only on acknowledge, while the host goes on with other work. Inbound traffic works the other way. A node requests, the bridge grants when its receive buffer is free, and the words land in the receive window. The bridge then raises an interrupt, which stays up until the host clears it after reading the data.

Top module: `host_array_bridge`

## Requirements
- R1: After a synchronous active-low reset, `rx_irq` is 0, `out_cmd` and `in_rsp` are 0 (idle/none), `out_dest` is 0 and `hst_rdata` is 0.
- R2: Host reads return data one cycle after the address is presented. The word address bits [11:10] select the window: 0 for registers, 2 for the transmit buffer (write-only, reads 0), 3 for the receive buffer. Register 1 (control) reads back the length-minus-one in [9:0], the destination index in [14:12] and the port ID in [23:16].
- R3: A control write with bit 31 set while idle starts a transfer, and status bit 0 (busy) reads 1. In the next cycle `out_cmd` is 1 (request), `out_data` carries the length-minus-one in [9:0] and the port ID in [23:16], and `out_dest` is the one-hot code of the destination index.
- R4: The request stays on `out_cmd` while `out_rsp` is 0 (none) or 3 (refuse). A response of 1 (acknowledge) or 2 (late acknowledge) moves the bridge to transfer mode (`out_cmd` = 2).
- R5: In transfer mode, `out_data` presents the transmit-buffer words in order from index 0. The bridge advances to the next word only on a cycle with `out_rsp` = 1. After the last word is acknowledged, `out_cmd` returns to 0 and busy clears.
- R6: While busy, control writes (including start) and transmit-buffer writes have no effect. The control readback and the words sent stay unchanged.
- R7: An inbound request (`in_cmd` = 1, with a header laid out like the R3 request word) while the receive buffer is free is answered with `in_rsp` = 1 in the next cycle. Each following `in_cmd` = 2 cycle stores `in_data` at consecutive receive-buffer indices from 0. A one-word transfer is valid.
- R8: After the last inbound word, `rx_irq` and status bit 1 read 1, and register 2 reads the received length-minus-one in [9:0] and the port ID in [23:16].
- R9: `rx_irq` stays 1 until a write to register 3 with bit 0 set. Writes with bit 0 clear have no effect. An inbound request that arrives while `rx_irq` is 1, including in the cycle of the clear write, is answered with `in_rsp` = 3, and the receive buffer is left unchanged.
- R10: Outbound and inbound transfers run at the same time without interfering, and host reads continue while either one is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_addr | input | 12 | Host word address |
| hst_we | input | 1 | Host write strobe |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, one cycle after the address |
| rx_irq | output | 1 | Data-receive interrupt |
| out_cmd | output | 2 | Outbound command: 0 idle, 1 request, 2 transfer |
| out_data | output | 32 | Outbound header or data word |
| out_dest | output | 8 | One-hot destination node vector |
| out_rsp | input | 2 | Response from destination: 0 none, 1 ack, 2 late ack, 3 refuse |
| in_cmd | input | 2 | Inbound command, same encoding as out_cmd |
| in_data | input | 32 | Inbound header or data word |
| in_rsp | output | 2 | Response to inbound sender, same encoding as out_rsp |

## Verification
The hardest state to reach is the one where the host's writes arrive while busy is set. The bench reaches it by holding the outbound request with a stream of refusals from the destination. This keeps the bridge busy for as long as needed while a second start and a transmit-buffer overwrite are applied, and the words later streamed out show whether either one slipped in. A second hard case is an inbound request that lands in the same cycle as the interrupt-clear write. The bench drives both in one cycle and expects a refusal, then repeats the inbound transfer once the flag is down. Inbound traffic is also injected while an outbound stream is being paced by alternating acknowledges, so that both engines work at once.

// File: rtl/hab_pkg.sv
// Shared encodings for the host-to-array bridge.
// Assumes a 32-bit link and at most 16 destination nodes.
package hab_pkg;
    typedef enum logic [1:0] {LK_IDLE = 2'd0, LK_REQ = 2'd1, LK_TRANS = 2'd2, LK_RSVD = 2'd3} link_cmd_e;
    typedef enum logic [1:0] {LR_NONE = 2'd0, LR_ACK = 2'd1, LR_LATE = 2'd2, LR_NACK = 2'd3} link_rsp_e;
    typedef enum logic [1:0] {TX_IDLE = 2'd0, TX_REQ = 2'd1, TX_SEND = 2'd2} tx_state_e;
    typedef enum logic {RX_IDLE = 1'b0, RX_RECV = 1'b1} rx_state_e;

    localparam logic [1:0] WIN_REG = 2'd0;
    localparam logic [1:0] WIN_TX  = 2'd2;
    localparam logic [1:0] WIN_RX  = 2'd3;

    localparam logic [1:0] RG_STATUS = 2'd0;
    localparam logic [1:0] RG_CTRL   = 2'd1;
    localparam logic [1:0] RG_RXINFO = 2'd2;
    localparam logic [1:0] RG_IRQCLR = 2'd3;

    localparam int F_DEST_LSB  = 12;
    localparam int F_PORT_LSB  = 16;
    localparam int F_START_BIT = 31;
    localparam int F_CLR_BIT   = 0;
endpackage

// File: rtl/hab_dpram.sv
// Simple two-port buffer: one synchronous write port, one synchronous read port.
// Assumes read-before-write when both ports hit the same word in one cycle.
// Contents are not reset; users must not rely on unwritten words.
module hab_dpram #(
    parameter int W     = 32,
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store on write strobe; read returns the word held before this edge.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/hab_tx_engine.sv
// Outbound engine: on start, latches length/destination/port, requests the
// destination, waits for a grant, then streams buffer words paced by ack.
// Assumes the buffer is not written while busy (guarded by the top level).
module hab_tx_engine
    import hab_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 10,
    parameter int NODES  = 8,
    parameter int DEST_W = 3,
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  len_m1,
    input  logic [DEST_W-1:0] dest,
    input  logic [PORT_W-1:0] port,
    output logic [IDX_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [1:0]        rsp,
    output logic              busy,
    output logic [1:0]        cmd,
    output logic [DATA_W-1:0] data,
    output logic [NODES-1:0]  dest_vec
);
    tx_state_e         st;
    logic [IDX_W-1:0]  idx, idx_nxt, len_q;
    logic [DEST_W-1:0] dest_q;
    logic [PORT_W-1:0] port_q;
    logic [DATA_W-1:0] hdr;
    logic              granted, word_acc, last;

    assign granted  = (rsp == LR_ACK) || (rsp == LR_LATE);
    assign word_acc = (st == TX_SEND) && (rsp == LR_ACK);
    assign last     = (idx == len_q);
    assign busy     = (st != TX_IDLE);

    // Next word index; also the buffer read address so rd_data tracks idx.
    always_comb begin
        idx_nxt = idx;
        if (start)                idx_nxt = '0;
        else if (word_acc && !last) idx_nxt = idx + 1'b1;
    end
    assign rd_addr = idx_nxt;

    // Sequence idle -> request -> send -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= TX_IDLE;
            idx    <= '0;
            len_q  <= '0;
            dest_q <= '0;
            port_q <= '0;
        end else begin
            idx <= idx_nxt;
            case (st)
                TX_IDLE: if (start) begin
                    st     <= TX_REQ;
                    len_q  <= len_m1;
                    dest_q <= dest;
                    port_q <= port;
                end
                TX_REQ:  if (granted) st <= TX_SEND;
                TX_SEND: if (word_acc && last) st <= TX_IDLE;
                default: st <= TX_IDLE;
            endcase
        end
    end

    // Header word carried during the request phase.
    always_comb begin
        hdr = '0;
        hdr[IDX_W-1:0] = len_q;
        hdr[F_PORT_LSB +: PORT_W] = port_q;
    end

    // Drive command and data from the current phase.
    always_comb begin
        case (st)
            TX_REQ:  begin cmd = LK_REQ;   data = hdr;     end
            TX_SEND: begin cmd = LK_TRANS; data = rd_data; end
            default: begin cmd = LK_IDLE;  data = '0;      end
        endcase
    end

    // One-hot destination decode, one bit per node.
    for (genvar g = 0; g < NODES; g++) begin : g_dest
        assign dest_vec[g] = busy && (dest_q == DEST_W'(g));
    end

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_REQ && rsp != LR_ACK && rsp != LR_LATE) |=> (cmd == LK_REQ));
    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_SEND && rsp != LR_ACK) |=> (cmd == LK_TRANS && $stable(data)));
    // R5
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_SEND && rsp == LR_ACK && idx == len_q) |=> !busy);
    // R3
    dest_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $onehot(dest_vec));
endmodule

// File: rtl/hab_rx_engine.sv
// Inbound engine: grants a request when the receive buffer is free,
// refuses it otherwise, and writes each transfer word at the next index.
// Pulses done on the last word; the top level owns the valid flag.
module hab_rx_engine
    import hab_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 10,
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd,
    input  logic [DATA_W-1:0] data,
    input  logic              hold,
    output logic [1:0]        rsp,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done,
    output logic [IDX_W-1:0]  hdr_len,
    output logic [PORT_W-1:0] hdr_port
);
    rx_state_e        st;
    logic [IDX_W-1:0] idx;
    logic [1:0]       rsp_q;

    assign wr_en   = (st == RX_RECV) && (cmd == LK_TRANS);
    assign wr_addr = idx;
    assign wr_data = data;
    assign done    = wr_en && (idx == hdr_len);
    assign rsp     = rsp_q;

    // Accept or refuse requests, then count stored words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= RX_IDLE;
            idx      <= '0;
            rsp_q    <= LR_NONE;
            hdr_len  <= '0;
            hdr_port <= '0;
        end else begin
            case (st)
                RX_IDLE: begin
                    if (cmd == LK_REQ) begin
                        if (hold) begin
                            rsp_q <= LR_NACK;
                        end else begin
                            st       <= RX_RECV;
                            idx      <= '0;
                            hdr_len  <= data[IDX_W-1:0];
                            hdr_port <= data[F_PORT_LSB +: PORT_W];
                            rsp_q    <= LR_ACK;
                        end
                    end else begin
                        rsp_q <= LR_NONE;
                    end
                end
                RX_RECV: begin
                    if (wr_en) begin
                        if (done) begin
                            st    <= RX_IDLE;
                            rsp_q <= LR_NONE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    // R9
    nack_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_IDLE && cmd == LK_REQ && hold) |=> (rsp == LR_NACK));
    // R7
    ack_in_recv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_RECV) |-> (rsp == LR_ACK));
    // R7
    write_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr <= hdr_len));
endmodule

// File: rtl/host_array_bridge.sv
// Host-to-array bridge top: decodes the host register/buffer port, holds the
// transmit and receive buffers and the receive-valid/interrupt flag, and
// connects the outbound and inbound engines to the array link.
// Assumes the host polls busy before filling the transmit window.
module host_array_bridge
    import hab_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int BUF_WORDS = 1024,
    parameter int NODES     = 8,
    parameter int PORT_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [$clog2(BUF_WORDS)+1:0]      hst_addr,
    input  logic                              hst_we,
    input  logic [DATA_W-1:0]                 hst_wdata,
    output logic [DATA_W-1:0]                 hst_rdata,
    output logic                              rx_irq,
    output logic [1:0]                        out_cmd,
    output logic [DATA_W-1:0]                 out_data,
    output logic [NODES-1:0]                  out_dest,
    input  logic [1:0]                        out_rsp,
    input  logic [1:0]                        in_cmd,
    input  logic [DATA_W-1:0]                 in_data,
    output logic [1:0]                        in_rsp
);
    localparam int IDX_W  = $clog2(BUF_WORDS);
    localparam int ADDR_W = IDX_W + 2;
    localparam int DEST_W = (NODES > 1) ? $clog2(NODES) : 1;

    logic [1:0]        win;
    logic [1:0]        rsel;
    logic              busy, ctl_wr, start, clr, rx_valid;
    logic [IDX_W-1:0]  cfg_len;
    logic [DEST_W-1:0] cfg_dest;
    logic [PORT_W-1:0] cfg_port;
    logic [DATA_W-1:0] reg_mux, reg_q, rx_q, tx_q;
    logic              sel_rx_q;
    logic [IDX_W-1:0]  tx_raddr, rx_waddr, rx_hlen;
    logic [PORT_W-1:0] rx_hport;
    logic [DATA_W-1:0] rx_wdata;
    logic              rx_we, rx_done;
    logic              unused_wdata;

    assign win    = hst_addr[ADDR_W-1 -: 2];
    assign rsel   = hst_addr[1:0];
    assign ctl_wr = hst_we && (win == WIN_REG) && (rsel == RG_CTRL);
    assign start  = ctl_wr && !busy && hst_wdata[F_START_BIT];
    assign clr    = hst_we && (win == WIN_REG) && (rsel == RG_IRQCLR) && hst_wdata[F_CLR_BIT];
    assign unused_wdata = ^hst_wdata;

    // Latch transfer settings from control writes made while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_len  <= '0;
            cfg_dest <= '0;
            cfg_port <= '0;
        end else if (ctl_wr && !busy) begin
            cfg_len  <= hst_wdata[IDX_W-1:0];
            cfg_dest <= hst_wdata[F_DEST_LSB +: DEST_W];
            cfg_port <= hst_wdata[F_PORT_LSB +: PORT_W];
        end
    end

    // Receive-valid flag doubles as the interrupt; set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_valid <= 1'b0;
        else if (rx_done) rx_valid <= 1'b1;
        else if (clr)     rx_valid <= 1'b0;
    end
    assign rx_irq = rx_valid;

    // Register read selection.
    always_comb begin
        reg_mux = '0;
        case (rsel)
            RG_STATUS: begin
                reg_mux[0] = busy;
                reg_mux[1] = rx_valid;
            end
            RG_CTRL: begin
                reg_mux[IDX_W-1:0]               = cfg_len;
                reg_mux[F_DEST_LSB +: DEST_W]    = cfg_dest;
                reg_mux[F_PORT_LSB +: PORT_W]    = cfg_port;
            end
            RG_RXINFO: begin
                reg_mux[IDX_W-1:0]               = rx_hlen;
                reg_mux[F_PORT_LSB +: PORT_W]    = rx_hport;
            end
            default: reg_mux = '0;
        endcase
    end

    // Register the read path so every window answers one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q    <= '0;
            sel_rx_q <= 1'b0;
        end else begin
            reg_q    <= (win == WIN_REG) ? reg_mux : '0;
            sel_rx_q <= (win == WIN_RX);
        end
    end
    assign hst_rdata = sel_rx_q ? rx_q : reg_q;

    hab_dpram #(.W(DATA_W), .DEPTH(BUF_WORDS), .AW(IDX_W)) u_txbuf (
        .clk   (clk),
        .we    (hst_we && (win == WIN_TX) && !busy),
        .waddr (hst_addr[IDX_W-1:0]),
        .wdata (hst_wdata),
        .raddr (tx_raddr),
        .rdata (tx_q)
    );

    hab_dpram #(.W(DATA_W), .DEPTH(BUF_WORDS), .AW(IDX_W)) u_rxbuf (
        .clk   (clk),
        .we    (rx_we),
        .waddr (rx_waddr),
        .wdata (rx_wdata),
        .raddr (hst_addr[IDX_W-1:0]),
        .rdata (rx_q)
    );

    hab_tx_engine #(
        .DATA_W(DATA_W), .IDX_W(IDX_W), .NODES(NODES), .DEST_W(DEST_W), .PORT_W(PORT_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .len_m1   (hst_wdata[IDX_W-1:0]),
        .dest     (hst_wdata[F_DEST_LSB +: DEST_W]),
        .port     (hst_wdata[F_PORT_LSB +: PORT_W]),
        .rd_addr  (tx_raddr),
        .rd_data  (tx_q),
        .rsp      (out_rsp),
        .busy     (busy),
        .cmd      (out_cmd),
        .data     (out_data),
        .dest_vec (out_dest)
    );

    hab_rx_engine #(.DATA_W(DATA_W), .IDX_W(IDX_W), .PORT_W(PORT_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (in_cmd),
        .data     (in_data),
        .hold     (rx_valid),
        .rsp      (in_rsp),
        .wr_en    (rx_we),
        .wr_addr  (rx_waddr),
        .wr_data  (rx_wdata),
        .done     (rx_done),
        .hdr_len  (rx_hlen),
        .hdr_port (rx_hport)
    );

    // R6
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_wr) |=> $stable({cfg_len, cfg_dest, cfg_port}));
    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !clr) |=> rx_valid);
    // R8
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> rx_valid);
endmodule

// File: tb/sim_host_array_bridge.sv
module sim_host_array_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] hst_addr = '0;
    logic        hst_we = 1'b0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        rx_irq;
    logic [1:0]  out_cmd;
    logic [31:0] out_data;
    logic [7:0]  out_dest;
    logic [1:0]  out_rsp = 2'd0;
    logic [1:0]  in_cmd = 2'd0;
    logic [31:0] in_data = '0;
    logic [1:0]  in_rsp;

    int    vectors = 0;
    int    fails = 0;
    int    cycles = 0;
    int    rmode = 0;
    bit    tog = 1'b0;
    bit    started = 1'b0;
    bit    ended = 1'b0;
    string phase = "R1";

    // reference model state
    int          m_ts, m_tidx, m_tlen, m_tdest, m_tport;
    int          m_cl, m_cd, m_cp;
    int          m_rs, m_ridx, m_rlen, m_rport, m_rsp;
    bit          m_rv;
    logic [31:0] m_rdata;
    logic [31:0] m_tx [1024];
    logic [31:0] m_rx [1024];

    always #(CLK_PERIOD/2) clk = ~clk;

    host_array_bridge u0 (
        .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_we(hst_we),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .rx_irq(rx_irq),
        .out_cmd(out_cmd), .out_data(out_data), .out_dest(out_dest), .out_rsp(out_rsp),
        .in_cmd(in_cmd), .in_data(in_data), .in_rsp(in_rsp)
    );

    // remote destination: response pattern chosen by rmode
    always @(posedge clk) begin
        #2;
        tog = ~tog;
        case (rmode)
            1: out_rsp = 2'd1;
            2: out_rsp = tog ? 2'd1 : 2'd0;
            3: out_rsp = 2'd3;
            4: out_rsp = 2'd2;
            default: out_rsp = 2'd0;
        endcase
    end

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        int win, rsel;
        bit busy, st, clr, done;
        logic [31:0] nrd;
        started = 1'b1;
        if (!rst_n) begin
            m_ts = 0; m_tidx = 0; m_tlen = 0; m_tdest = 0; m_tport = 0;
            m_cl = 0; m_cd = 0; m_cp = 0;
            m_rs = 0; m_ridx = 0; m_rlen = 0; m_rport = 0; m_rsp = 0;
            m_rv = 0; m_rdata = 0;
        end else begin
            win  = int'(hst_addr[11:10]);
            rsel = int'(hst_addr[1:0]);
            busy = (m_ts != 0);
            nrd = 0;
            if (win == 0) begin
                if (rsel == 0) nrd = {30'd0, m_rv, busy};
                else if (rsel == 1) nrd = m_cl | (m_cd << 12) | (m_cp << 16);
                else if (rsel == 2) nrd = m_rlen | (m_rport << 16);
            end else if (win == 3) nrd = m_rx[hst_addr[9:0]];
            st = 0; clr = 0;
            if (hst_we) begin
                if (win == 0 && rsel == 1 && !busy) begin
                    m_cl = int'(hst_wdata[9:0]); m_cd = int'(hst_wdata[14:12]);
                    m_cp = int'(hst_wdata[23:16]); st = hst_wdata[31];
                end
                if (win == 0 && rsel == 3 && hst_wdata[0]) clr = 1;
                if (win == 2 && !busy) m_tx[hst_addr[9:0]] = hst_wdata;
            end
            if (m_ts == 1 && (out_rsp == 2'd1 || out_rsp == 2'd2)) m_ts = 2;
            else if (m_ts == 2 && out_rsp == 2'd1) begin
                if (m_tidx == m_tlen) m_ts = 0; else m_tidx++;
            end
            if (st) begin
                m_ts = 1; m_tidx = 0; m_tlen = m_cl; m_tdest = m_cd; m_tport = m_cp;
            end
            done = 0;
            if (m_rs == 0) begin
                if (in_cmd == 2'd1) begin
                    if (m_rv) m_rsp = 3;
                    else begin
                        m_rs = 1; m_ridx = 0; m_rlen = int'(in_data[9:0]);
                        m_rport = int'(in_data[23:16]); m_rsp = 1;
                    end
                end else m_rsp = 0;
            end else if (in_cmd == 2'd2) begin
                m_rx[m_ridx] = in_data;
                if (m_ridx == m_rlen) begin m_rs = 0; done = 1; m_rsp = 0; end
                else m_ridx++;
            end
            if (done) m_rv = 1; else if (clr) m_rv = 0;
            m_rdata = nrd;
        end
    end

    task automatic cmp(string what, logic [31:0] got, logic [31:0] exp);
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, got, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        logic [31:0] e_data;
        if (started && !ended) begin
            vectors++;
            e_data = (m_ts == 1) ? (m_tlen | (m_tport << 16)) : (m_ts == 2) ? m_tx[m_tidx] : 32'd0;
            cmp("out_cmd", {30'd0, out_cmd}, m_ts);
            cmp("out_data", out_data, e_data);
            cmp("out_dest", {24'd0, out_dest}, (m_ts != 0) ? (32'd1 << m_tdest) : 32'd0);
            cmp("in_rsp", {30'd0, in_rsp}, m_rsp);
            cmp("rx_irq", {31'd0, rx_irq}, {31'd0, m_rv});
            cmp("hst_rdata", hst_rdata, m_rdata);
        end
    end

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic host_wr(logic [11:0] a, logic [31:0] d);
        hst_we = 1'b1; hst_addr = a; hst_wdata = d;
        step();
        hst_we = 1'b0;
    endtask

    task automatic host_rd(string tag, logic [11:0] a, logic [31:0] exp);
        hst_addr = a;
        step();
        chk(tag, "read", hst_rdata, exp);
    endtask

    task automatic rx_send(int len_m1, int port, logic [31:0] base);
        in_cmd = 2'd1; in_data = len_m1 | (port << 16);
        step();
        chk("R7", "grant", {30'd0, in_rsp}, 32'd1);
        for (int i = 0; i <= len_m1; i++) begin
            in_cmd = 2'd2; in_data = base + i * 3;
            step();
        end
        in_cmd = 2'd0; in_data = 0;
    endtask

    task automatic wait_tx_idle(int maxc);
        for (int i = 0; i < maxc && out_cmd != 2'd0; i++) step();
        chk("R5", "transfer ends", {30'd0, out_cmd}, 32'd0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            fails++;
            $display("FAIL R5 watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "irq", {31'd0, rx_irq}, 0);
        chk("R1", "out_cmd", {30'd0, out_cmd}, 0);
        chk("R1", "in_rsp", {30'd0, in_rsp}, 0);
        chk("R1", "out_dest", {24'd0, out_dest}, 0);
        chk("R1", "rdata", hst_rdata, 0);

        // R2 buffer fill and register readback
        phase = "R2";
        for (int i = 0; i < 5; i++) host_wr(12'h800 + 12'(i), 32'hA000_0000 + i * 17);
        host_wr(12'h001, 32'h4 | (32'd5 << 12) | (32'h3C << 16));
        host_rd("R2", 12'h001, 32'h4 | (32'd5 << 12) | (32'h3C << 16));
        host_rd("R2", 12'h000, 32'h0);
        host_rd("R2", 12'h802, 32'h0);

        // R3 start, R4 request held under refusals
        phase = "R4";
        rmode = 3;
        host_wr(12'h001, 32'h8000_0000 | 32'h4 | (32'd5 << 12) | (32'h3C << 16));
        chk("R3", "out_cmd", {30'd0, out_cmd}, 1);
        chk("R3", "header", out_data, 32'h4 | (32'h3C << 16));
        chk("R3", "out_dest", {24'd0, out_dest}, 32'h20);
        host_rd("R3", 12'h000, 32'h1);

        // R6 writes while busy
        phase = "R6";
        host_wr(12'h001, 32'h8000_0000 | 32'h2 | (32'd1 << 12) | (32'h11 << 16));
        host_wr(12'h800, 32'hDEAD_BEEF);
        host_rd("R6", 12'h001, 32'h4 | (32'd5 << 12) | (32'h3C << 16));
        step();
        chk("R4", "held on refuse", {30'd0, out_cmd}, 1);
        rmode = 0;
        step(); step();
        chk("R4", "held on none", {30'd0, out_cmd}, 1);
        rmode = 4;
        step(); step();
        rmode = 2;
        chk("R4", "late grant", {30'd0, out_cmd}, 2);
        chk("R6", "word0 kept", out_data, 32'hA000_0000);

        // R10 inbound while outbound is streaming
        phase = "R10";
        in_cmd = 2'd1; in_data = 32'd3 | (32'h21 << 16);
        step();
        chk("R10", "tx still active", {31'd0, out_cmd != 2'd0}, 1);
        chk("R7", "grant", {30'd0, in_rsp}, 1);
        for (int i = 0; i < 4; i++) begin
            in_cmd = 2'd2; in_data = 32'h5500 + i * 3;
            step();
        end
        in_cmd = 2'd0;
        chk("R8", "irq", {31'd0, rx_irq}, 1);
        phase = "R5";
        wait_tx_idle(40);
        rmode = 0;
        host_rd("R5", 12'h000, 32'h2);

        // R8 receive info and buffer
        phase = "R8";
        host_rd("R8", 12'h002, 32'd3 | (32'h21 << 16));
        for (int i = 0; i < 4; i++) host_rd("R8", 12'hC00 + 12'(i), 32'h5500 + i * 3);

        // R9 refusal while flag set, clear handling
        phase = "R9";
        in_cmd = 2'd1; in_data = 32'd0;
        step();
        chk("R9", "refuse", {30'd0, in_rsp}, 3);
        in_cmd = 2'd0;
        step();
        host_rd("R9", 12'hC00, 32'h5500);
        host_wr(12'h003, 32'h2);
        chk("R9", "irq kept", {31'd0, rx_irq}, 1);
        hst_we = 1'b1; hst_addr = 12'h003; hst_wdata = 32'h1;
        in_cmd = 2'd1; in_data = 32'd0;
        step();
        hst_we = 1'b0; in_cmd = 2'd0;
        chk("R9", "refuse at clear", {30'd0, in_rsp}, 3);
        chk("R9", "irq cleared", {31'd0, rx_irq}, 0);
        step();

        // R7 single-word inbound transfer
        phase = "R7";
        rx_send(0, 7, 32'hBEEF);
        chk("R8", "irq single", {31'd0, rx_irq}, 1);
        host_rd("R8", 12'h002, 32'd7 << 16);
        host_rd("R7", 12'hC00, 32'hBEEF);
        host_wr(12'h003, 32'h1);

        // R5 full-length outbound transfer to the highest node
        phase = "R5";
        for (int i = 0; i < 1024; i++) host_wr(12'h800 + 12'(i), 32'h1000_0000 + i * 7);
        rmode = 1;
        host_wr(12'h001, 32'h8000_0000 | 32'd1023 | (32'd7 << 12) | (32'hFF << 16));
        chk("R3", "out_dest top", {24'd0, out_dest}, 32'h80);
        wait_tx_idle(1100);

        // R3 single-word transfer to node 0
        phase = "R3";
        host_wr(12'h800, 32'h0BAD_F00D);
        host_wr(12'h001, 32'h8000_0000);
        chk("R3", "out_dest zero", {24'd0, out_dest}, 32'h1);
        wait_tx_idle(10);
        host_rd("R5", 12'h000, 32'h0);
        repeat (3) step();
        finish_run();
    end
endmodule